// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recently used page mappings, each pairing a virtual page number with a physical frame number. A lookup presents a virtual page number. The block compares it against every valid slot at once and answers one clock later with a hit flag, the frame number, the access-rights field and the slot's status bits. When a lookup misses, the requester walks the page table elsewhere and then loads the result through the fill port.

Each slot holds a valid bit, a dirty bit, a reference bit and an access-rights field beside its page/frame pair. Any lookup that hits marks its slot as referenced. A store lookup that hits also marks the slot dirty. A fill picks its slot in this order: a slot that already maps the same page, then the lowest free slot, then the slot under a round-robin pointer. A flush input drops every mapping in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every slot is invalid and `rsp_valid` is 0. A lookup made right after reset misses.
- R2: A response appears exactly one cycle after its request: `rsp_valid` is high in the cycle after `lk_valid` was high, and low otherwise. Back-to-back requests give back-to-back responses.
- R3: A lookup whose page matches a valid slot returns `rsp_hit`=1 with that slot's frame number, rights field, dirty bit and reference bit, as they were before this access. A miss returns `rsp_hit`=0 with frame, rights, dirty and reference all zero.
- R4: Every hit sets the reference bit of the slot it hit. A later lookup of the same page shows `rsp_ref`=1.
- R5: A hit with `lk_store`=1 (store access) sets the slot's dirty bit. A hit with `lk_store`=0 (load) leaves the dirty bit unchanged.
- R6: A fill to a page that no valid slot holds goes to the lowest-numbered invalid slot, if one exists. A filled slot takes its dirty bit from `fill_dirty` and its reference bit is 0.
- R7: When every slot is valid, a fill to a new page replaces the slot under a round-robin pointer. The pointer is 0 after reset and moves up by one after each replacement, wrapping from ENTRIES-1 to 0. Only reset and replacements change the pointer.
- R8: A fill whose page already sits in a valid slot overwrites that slot in place. It uses up no other slot and does not move the pointer, so no page is ever held twice.
- R9: `flush` invalidates all slots in one cycle. A fill presented in the same cycle as a flush is dropped.
- R10: A lookup presented in the same cycle as a fill sees the contents from before the fill. When both touch the same slot, the fill's values win over the status update from the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_store | input | 1 | 1 = store access, 0 = load access |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | VPN_W | Virtual page number of the new mapping |
| fill_pfn | input | PFN_W | Physical frame number of the new mapping |
| fill_perm | input | PERM_W | Access-rights field of the new mapping |
| fill_dirty | input | 1 | Initial dirty bit of the new mapping |
| flush | input | 1 | Invalidate all slots |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Frame number on a hit, zero on a miss |
| rsp_perm | output | PERM_W | Rights field on a hit, zero on a miss |
| rsp_dirty | output | 1 | Dirty bit of the hit slot before this access |
| rsp_ref | output | 1 | Reference bit of the hit slot before this access |

## Verification
Repeated load and store lookups of a single page show how the status bits move: a load sets only the reference bit, and a store also sets the dirty bit. Filling a free table, then filling it again with one page repeated, shows whether a repeated page takes a slot of its own. Filling past capacity, followed by misses on specific old pages, shows the order in which slots are freed and replaced, the pointer wrap, and that an in-place overwrite leaves the pointer where it was. A fill issued in the same cycle as a lookup or a flush shows which operation wins when they collide.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    SLOT_REUSE = 2'd0,
    SLOT_FREE  = 2'd1,
    SLOT_EVICT = 2'd2
  } slot_pick_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]              key,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0]            valid,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic [IDX_W-1:0]              hit_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_alloc.sv
module xlat_alloc
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_go,
  input  logic               match_any,
  input  logic [IDX_W-1:0]   match_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   victim
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_ptr;
  slot_pick_e       pick;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (match_any) begin
      pick   = SLOT_REUSE;
      victim = match_idx;
    end else if (free_any) begin
      pick   = SLOT_FREE;
      victim = free_idx;
    end else begin
      pick   = SLOT_EVICT;
      victim = rr_ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (fill_go && pick == SLOT_EVICT) begin
      if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
      else rr_ptr <= rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int PERM_W  = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_store,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fill_dirty,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              rsp_dirty,
  output logic              rsp_ref
);
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             dirty_q;
  logic [ENTRIES-1:0]             ref_q;

  logic [ENTRIES-1:0] lk_hit_vec;
  logic [ENTRIES-1:0] fill_hit_vec;
  logic [IDX_W-1:0]   lk_idx;
  logic [IDX_W-1:0]   fill_idx;
  logic [IDX_W-1:0]   victim;
  logic               lk_any;
  logic               fill_any;
  logic               lk_take;
  logic               fill_go;

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .key(lk_vpn), .tags(vpn_q), .valid(valid_q),
    .hit_vec(lk_hit_vec), .hit_idx(lk_idx)
  );

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
    .key(fill_vpn), .tags(vpn_q), .valid(valid_q),
    .hit_vec(fill_hit_vec), .hit_idx(fill_idx)
  );

  assign lk_any   = |lk_hit_vec;
  assign fill_any = |fill_hit_vec;
  assign lk_take  = lk_valid && lk_any;
  assign fill_go  = fill_valid && !flush;

  xlat_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk(clk), .rst(rst), .fill_go(fill_go),
    .match_any(fill_any), .match_idx(fill_idx),
    .valid(valid_q), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vpn_q     <= '0;
      pfn_q     <= '0;
      perm_q    <= '0;
      valid_q   <= '0;
      dirty_q   <= '0;
      ref_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
      rsp_dirty <= 1'b0;
      rsp_ref   <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_take;
      rsp_pfn   <= lk_take ? pfn_q[lk_idx]  : '0;
      rsp_perm  <= lk_take ? perm_q[lk_idx] : '0;
      rsp_dirty <= lk_take ? dirty_q[lk_idx] : 1'b0;
      rsp_ref   <= lk_take ? ref_q[lk_idx]  : 1'b0;

      // status update from the access; a fill below overrides it
      if (lk_take) begin
        ref_q[lk_idx] <= 1'b1;
        if (lk_store) dirty_q[lk_idx] <= 1'b1;
      end

      if (flush) begin
        valid_q <= '0;
      end else if (fill_valid) begin
        vpn_q[victim]   <= fill_vpn;
        pfn_q[victim]   <= fill_pfn;
        perm_q[victim]  <= fill_perm;
        valid_q[victim] <= 1'b1;
        dirty_q[victim] <= fill_dirty;
        ref_q[victim]   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic               fill_valid,
  input logic               flush,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [PFN_W-1:0]   rsp_pfn,
  input logic               rsp_dirty,
  input logic               rsp_ref,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] lk_hit_vec
);
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (valid_q == '0 && !rsp_valid));

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0 && !rsp_dirty && !rsp_ref));

  assert_fill_lands_R6: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !flush) |=> (valid_q != '0));

  assert_single_match_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .fill_valid(fill_valid),
  .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_pfn(rsp_pfn), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref),
  .valid_q(valid_q), .lk_hit_vec(lk_hit_vec)
);

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_store = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        fill_valid = 1'b0, fill_dirty = 1'b0, flush = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [15:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        rsp_valid, rsp_hit, rsp_dirty, rsp_ref;
  logic [15:0] rsp_pfn;
  logic [2:0]  rsp_perm;

  typedef struct packed {
    logic        hit;
    logic [15:0] pfn;
    logic [2:0]  perm;
    logic        d;
    logic        r;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  always #2.5 clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_store(lk_store), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_dirty(fill_dirty),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm), .rsp_dirty(rsp_dirty),
    .rsp_ref(rsp_ref)
  );

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 response with no request: got 1 expected 0");
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_hit, rsp_pfn, rsp_perm, rsp_dirty, rsp_ref} != e) begin
          errors++;
          $display("FAIL %s got hit=%0b pfn=%h perm=%0d d=%0b r=%0b expected hit=%0b pfn=%h perm=%0d d=%0b r=%0b",
                   t, rsp_hit, rsp_pfn, rsp_perm, rsp_dirty, rsp_ref,
                   e.hit, e.pfn, e.perm, e.d, e.r);
        end
      end
    end
  end

  task automatic drive(input bit dl, input [19:0] lv, input bit st,
                       input bit df, input [19:0] fv, input [15:0] fp,
                       input [2:0] fr, input bit fd, input bit fl);
    lk_valid = dl; lk_vpn = lv; lk_store = st;
    fill_valid = df; fill_vpn = fv; fill_pfn = fp; fill_perm = fr;
    fill_dirty = fd; flush = fl;
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; flush = 0; lk_store = 0;
  endtask

  task automatic expect_rsp(input bit h, input [15:0] p, input [2:0] pr,
                            input bit d, input bit r, input string t);
    exp_t e;
    e = '{hit: h, pfn: p, perm: pr, d: d, r: r};
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic look(input [19:0] v, input bit st, input bit h,
                      input [15:0] p, input [2:0] pr, input bit d,
                      input bit r, input string t);
    expect_rsp(h, p, pr, d, r, t);
    drive(1, v, st, 0, '0, '0, '0, 0, 0);
  endtask

  task automatic miss(input [19:0] v, input string t);
    look(v, 0, 0, '0, '0, 0, 0, t);
  endtask

  task automatic fill(input [19:0] v, input [15:0] p, input [2:0] pr, input bit d);
    drive(0, '0, 0, 1, v, p, pr, d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rsp_valid in reset: got %0b expected 0", rsp_valid);
    end
    rst = 0;
    miss(20'h00005, "R1 lookup after reset");

    fill(20'h100, 16'hA00, 3'd0, 0);
    fill(20'h101, 16'hA01, 3'd1, 0);
    fill(20'h102, 16'hA02, 3'd2, 0);
    look(20'h101, 0, 1, 16'hA01, 3'd1, 0, 0, "R3 first hit");
    look(20'h101, 1, 1, 16'hA01, 3'd1, 0, 1, "R4 ref set by hit");
    look(20'h101, 0, 1, 16'hA01, 3'd1, 1, 1, "R5 dirty set by store");
    look(20'h102, 0, 1, 16'hA02, 3'd2, 0, 0, "R3 second slot");
    look(20'h102, 0, 1, 16'hA02, 3'd2, 0, 1, "R5 load keeps dirty clear");
    miss(20'h777, "R3 miss zeros");
    @(negedge clk);
    miss(20'h778, "R2 after idle cycle");

    // in-place overwrite, then fill to capacity
    fill(20'h101, 16'h0BBB, 3'd7, 0);
    look(20'h101, 0, 1, 16'h0BBB, 3'd7, 0, 0, "R8 overwrite in place");
    for (int i = 3; i < N; i++) fill(20'h100 + i, 16'hA00 + i, 3'(i), 0);
    look(20'h100, 0, 1, 16'hA00, 3'd0, 0, 0, "R8 slot0 kept");
    look(20'h101, 0, 1, 16'h0BBB, 3'd7, 0, 1, "R8 overwritten slot");
    look(20'h102, 0, 1, 16'hA02, 3'd2, 0, 1, "R6 slot2");
    for (int i = 3; i < N; i++)
      look(20'h100 + i, 0, 1, 16'hA00 + i, 3'(i), 0, 0, "R6 fill order");

    // replacement order
    fill(20'h200, 16'hC00, 3'd0, 1);
    miss(20'h100, "R7 first replace slot0");
    look(20'h200, 0, 1, 16'hC00, 3'd0, 1, 0, "R6 fill dirty and ref");
    fill(20'h201, 16'hC01, 3'd1, 0);
    miss(20'h101, "R7 second replace slot1");
    look(20'h102, 0, 1, 16'hA02, 3'd2, 0, 1, "R7 slot2 untouched");
    for (int i = 2; i < N; i++) fill(20'h200 + i, 16'hC00 + i, 3'(i), 0);
    fill(20'h210, 16'hC10, 3'd0, 0);
    miss(20'h200, "R7 wrap replaces slot0");
    look(20'h201, 0, 1, 16'hC01, 3'd1, 0, 0, "R7 slot1 kept after wrap");
    look(20'h210, 0, 1, 16'hC10, 3'd0, 0, 0, "R7 new page");
    fill(20'h205, 16'h0DDD, 3'd6, 0);
    fill(20'h211, 16'hC11, 3'd1, 0);
    miss(20'h201, "R8 pointer not moved by overwrite");
    look(20'h205, 0, 1, 16'h0DDD, 3'd6, 0, 0, "R8 overwrite while full");
    look(20'h211, 0, 1, 16'hC11, 3'd1, 0, 0, "R7 replace slot1");

    // lookup and fill of the same page in one cycle
    expect_rsp(1, 16'hC03, 3'd3, 0, 0, "R10 lookup sees old contents");
    drive(1, 20'h203, 1, 1, 20'h203, 16'h0EEE, 3'd5, 0, 0);
    look(20'h203, 0, 1, 16'h0EEE, 3'd5, 0, 0, "R10 fill wins over status");

    // flush with a fill in the same cycle
    drive(0, '0, 0, 1, 20'h300, 16'h0F00, 3'd0, 0, 1);
    miss(20'h202, "R9 flush cleared");
    miss(20'h300, "R9 fill dropped");
    for (int i = 0; i < N; i++) fill(20'h300 + i, 16'h0F00 + i, 3'(i), 0);
    fill(20'h310, 16'h0F10, 3'd0, 0);
    miss(20'h302, "R7 pointer kept across flush");
    look(20'h300, 0, 1, 16'h0F00, 3'd0, 0, 0, "R6 refill after flush");
    look(20'h310, 0, 1, 16'h0F10, 3'd0, 0, 0, "R7 replacement after flush");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule